// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block evaluates a set of Boolean functions written as sums of products over a small input vector. Each of its product rows forms the AND of any chosen input literals, either true or inverted. Each output forms the OR of any chosen product rows. The row count is a free parameter and is not tied to two to the power of the input count, so only the rows a function needs are built.

Before use, both planes are filled through a one-bit serial port. Each accepted bit is qualified by a valid strobe. A done flag rises once the last plane bit has arrived. Until then every output stays low. After that the planes are frozen until reset.

The outputs are combinational by default. A parameter can place one register stage in front of them.

Top module: `sop_pla`

## Requirements
- R1: Product row p is the AND of the literals it enables. Its 2*N_IN-bit field sits at and-plane bits [p*2*N_IN +: 2*N_IN]. Within that field, bit 2*i enables input i in true form and bit 2*i+1 enables input i inverted.
- R2: Output o is the OR of the product rows it selects. Or-plane bit o*N_TERM+p selects row p for output o.
- R3: A product row with no literal enabled evaluates to 1.
- R4: A product row that enables both the true and the inverted literal of the same input evaluates to 0.
- R5: An output that selects no product row evaluates to 0.
- R6: A configuration bit is taken from cfg_data only in a cycle with cfg_valid high. Bits arrive most significant first over the concatenation {and-plane, or-plane}, so the and-plane is loaded first. cfg_done rises in the cycle after exactly N_TERM*2*N_IN + N_OUT*N_TERM bits have been accepted, and not before.
- R7: While cfg_done is low, out_vec is all zeros, whatever in_vec holds.
- R8: Once cfg_done is high, it stays high, and further configuration bits change neither the planes nor the outputs.
- R9: With REG_OUT=0, out_vec follows in_vec in the same cycle. With REG_OUT=1, out_vec shows the value of the previous cycle's inputs and resets to zero.
- R10: With the matching plane contents, inputs {cin, b, a} on in_vec[2:0] produce the sum on out_vec[0] and the carry on out_vec[1], which makes the array a full adder.
- R11: An asynchronous low level on rst_n clears cfg_done, the planes, the bit count and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Qualifies cfg_data |
| cfg_data | input | 1 | Serial configuration bit, MSB first |
| in_vec | input | N_IN | Primary inputs |
| cfg_done | output | 1 | Both planes fully loaded |
| out_vec | output | N_OUT | Sum-of-products outputs |

## Verification
The bench builds two copies with N_IN=3, N_TERM=9 and N_OUT=5, one combinational and one registered. Both copies receive the same serial stream and the same inputs. Seven rows hold a full adder. An eighth row is left empty. A ninth row holds a contradictory pair. Four outputs select rows and the fifth selects none. These values put the empty-row, contradictory-row and empty-output cases within reach, along with the adder truth table and the one-cycle latency difference. The 99-bit stream is broken up by idle cycles with toggling data to exercise valid gating. Extra bits sent after completion test the lock, and a mid-run reset followed by a reload with a changed or-plane tests reset clearing.

// File: rtl/pla_pkg.sv
package pla_pkg;
  function automatic int cfg_len(input int n_in, input int n_term, input int n_out);
    return n_term * 2 * n_in + n_out * n_term;
  endfunction
endpackage

// File: rtl/pla_cfg_loader.sv
module pla_cfg_loader #(
  parameter int TOTAL = 16,
  parameter int CW    = $clog2(TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic             cfg_data,
  output logic [TOTAL-1:0] cfg_bits,
  output logic [CW-1:0]    bit_cnt,
  output logic             cfg_done
);
  logic [TOTAL-1:0] sr_q, sr_nxt;
  logic [CW-1:0]    cnt_q, cnt_nxt;

  assign cfg_done = (cnt_q == CW'(TOTAL));

  always_comb begin
    sr_nxt  = sr_q;
    cnt_nxt = cnt_q;
    if (cfg_valid && !cfg_done) begin
      sr_nxt  = {sr_q[TOTAL-2:0], cfg_data};
      cnt_nxt = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  assign cfg_bits = sr_q;
  assign bit_cnt  = cnt_q;
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 8,
  localparam int LW    = 2 * N_IN
) (
  input  logic [N_IN-1:0]        lit_in,
  input  logic [N_TERM*LW-1:0]   and_bits,
  output logic [N_TERM-1:0]      term
);
  logic [LW-1:0] lits;

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      lits[2*i]   = lit_in[i];
      lits[2*i+1] = ~lit_in[i];
    end
  end

  for (genvar p = 0; p < N_TERM; p++) begin : g_row
    assign term[p] = &(lits | ~and_bits[p*LW +: LW]);
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 8,
  parameter int N_OUT  = 2
) (
  input  logic [N_TERM-1:0]       term,
  input  logic [N_OUT*N_TERM-1:0] or_bits,
  output logic [N_OUT-1:0]        sop
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_col
    assign sop[o] = |(term & or_bits[o*N_TERM +: N_TERM]);
  end
endmodule

// File: rtl/sop_pla.sv
module sop_pla #(
  parameter int N_IN    = 3,
  parameter int N_TERM  = 8,
  parameter int N_OUT   = 2,
  parameter bit REG_OUT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic             cfg_data,
  input  logic [N_IN-1:0]  in_vec,
  output logic             cfg_done,
  output logic [N_OUT-1:0] out_vec
);
  localparam int AND_W = N_TERM * 2 * N_IN;
  localparam int OR_W  = N_OUT * N_TERM;
  localparam int TOTAL = pla_pkg::cfg_len(N_IN, N_TERM, N_OUT);
  localparam int CW    = $clog2(TOTAL + 1);

  logic [TOTAL-1:0]  cfg_bits;
  logic [CW-1:0]     bit_cnt;
  logic [N_TERM-1:0] term;
  logic [N_OUT-1:0]  sop_val;

  pla_cfg_loader #(.TOTAL(TOTAL), .CW(CW)) u_loader (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_valid(cfg_valid),
    .cfg_data (cfg_data),
    .cfg_bits (cfg_bits),
    .bit_cnt  (bit_cnt),
    .cfg_done (cfg_done)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .lit_in  (in_vec),
    .and_bits(cfg_bits[TOTAL-1 -: AND_W]),
    .term    (term)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .term   (term),
    .or_bits(cfg_bits[OR_W-1:0]),
    .sop    (sop_val)
  );

  if (REG_OUT) begin : g_reg
    logic [N_OUT-1:0] out_q, out_nxt;
    always_comb out_nxt = cfg_done ? sop_val : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= '0;
      else        out_q <= out_nxt;
    end
    assign out_vec = out_q;
  end else begin : g_comb
    assign out_vec = cfg_done ? sop_val : '0;
  end
endmodule

// File: rtl/sop_pla_checker.sv
module sop_pla_checker #(
  parameter int N_IN    = 3,
  parameter int N_TERM  = 8,
  parameter int N_OUT   = 2,
  parameter bit REG_OUT = 1'b0,
  localparam int TOTAL  = pla_pkg::cfg_len(N_IN, N_TERM, N_OUT),
  localparam int CW     = $clog2(TOTAL + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_valid,
  input logic             cfg_done,
  input logic [CW-1:0]    bit_cnt,
  input logic [TOTAL-1:0] cfg_bits,
  input logic [N_OUT-1:0] sop_val,
  input logic [N_OUT-1:0] out_vec
);
  AST_ZERO_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> out_vec == '0); // R7
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> cfg_done); // R8
  AST_DONE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_done) |-> $past(cfg_valid)); // R6
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CW'(TOTAL)); // R6
  AST_PLANES_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> $stable(cfg_bits)); // R8

  if (REG_OUT) begin : g_reg_chk
    AST_REG_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_done && $past(cfg_done)) |-> out_vec == $past(sop_val)); // R9
  end else begin : g_comb_chk
    AST_COMB_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |-> out_vec == sop_val); // R9
  end
endmodule

bind sop_pla sop_pla_checker #(
  .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .REG_OUT(REG_OUT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_valid(cfg_valid),
  .cfg_done (cfg_done),
  .bit_cnt  (bit_cnt),
  .cfg_bits (cfg_bits),
  .sop_val  (sop_val),
  .out_vec  (out_vec)
);

// File: tb/sop_pla_bench.sv
module sop_pla_bench;
  localparam int N = 3, P = 9, M = 5;
  localparam int TOTAL = P * 2 * N + M * P;

  logic clk, rst_n, cfg_valid, cfg_data;
  logic [N-1:0] in_vec;
  logic done_c, done_r;
  logic [M-1:0] out_c, out_r;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R11";

  bit and_t [P][N];
  bit and_c [P][N];
  bit or_s  [M][P];

  int m_cnt; bit m_done; logic [M-1:0] m_q;

  sop_pla #(.N_IN(N), .N_TERM(P), .N_OUT(M), .REG_OUT(1'b0)) u_sop_pla (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_data(cfg_data),
    .in_vec(in_vec), .cfg_done(done_c), .out_vec(out_c));
  sop_pla #(.N_IN(N), .N_TERM(P), .N_OUT(M), .REG_OUT(1'b1)) u_sop_pla_r (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_data(cfg_data),
    .in_vec(in_vec), .cfg_done(done_r), .out_vec(out_r));

  initial begin clk = 1'b0; forever #10 clk = ~clk; end

  function automatic bit stream_bit(input int k);
    int j, p, r;
    if (k >= M * P) begin
      j = k - M * P; p = j / (2 * N); r = j % (2 * N);
      return (r % 2 == 0) ? and_t[p][r/2] : and_c[p][r/2];
    end
    return or_s[k / P][k % P];
  endfunction

  function automatic logic [M-1:0] ref_eval(input logic [N-1:0] x);
    logic [M-1:0] res = '0;
    for (int o = 0; o < M; o++) begin
      for (int p = 0; p < P; p++) begin
        bit t = 1'b1;
        if (!or_s[o][p]) continue;
        for (int i = 0; i < N; i++) begin
          if (and_t[p][i] && !x[i]) t = 1'b0;
          if (and_c[p][i] && x[i])  t = 1'b0;
        end
        if (t) res[o] = 1'b1;
      end
    end
    return res;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model, updated on each edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_done = 1'b0; m_q = '0;
    end else begin
      m_q = m_done ? ref_eval(in_vec) : '0;
      if (cfg_valid && !m_done) begin
        m_cnt++;
        if (m_cnt == TOTAL) m_done = 1'b1;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    chk(cur_req, "done comb", int'(done_c), int'(m_done));
    chk(cur_req, "done reg",  int'(done_r), int'(m_done));
    chk(cur_req, "out comb",  int'(out_c),  int'(m_done ? ref_eval(in_vec) : '0));
    chk(cur_req, "out reg",   int'(out_r),  int'(m_q));
  end

  task automatic step(); @(posedge clk); #2; endtask

  task automatic load_all();
    int sent = 0;
    for (int k = TOTAL - 1; k >= 0; k--) begin
      cfg_valid = 1'b1; cfg_data = stream_bit(k); in_vec = N'(k);
      step(); sent++;
      if (sent % 7 == 0) begin
        cfg_valid = 1'b0; cfg_data = ~stream_bit(k); step();
      end
      if (sent == TOTAL - 1) begin
        @(negedge clk); #1;
        chk("R6", "done early", int'(done_c), 0);
        chk("R7", "out before done", int'(out_c), 0);
        #5;
      end
    end
    cfg_valid = 1'b0;
    @(negedge clk); #1;
    chk("R6", "done after last bit", int'(done_c), 1);
    #5;
  endtask

  task automatic sweep_adder();
    for (int v = 0; v < 8; v++) begin
      int a, b, c;
      in_vec = N'(v); a = v & 1; b = (v >> 1) & 1; c = (v >> 2) & 1;
      @(negedge clk); #1;
      chk("R10", "sum", int'(out_c[0]), (a + b + c) % 2);
      chk("R10", "carry", int'(out_c[1]), (a + b + c) / 2);
      chk("R1", "adder terms", int'(out_c[1:0]), (a + b + c));
      chk("R3", "empty row", int'(out_c[2]), 1);
      chk("R4", "contradictory row", int'(out_c[3]), 0);
      @(negedge clk); #1;
      chk("R9", "registered sum", int'(out_r[0]), (a + b + c) % 2);
      step();
    end
  endtask

  initial begin
    rst_n = 1'b1; cfg_valid = 1'b0; cfg_data = 1'b0; in_vec = '0;
    // full adder on rows 0..6, row 7 empty, row 8 contradictory
    and_t[0][2] = 1; and_c[0][1] = 1; and_c[0][0] = 1;
    and_c[1][2] = 1; and_t[1][1] = 1; and_c[1][0] = 1;
    and_c[2][2] = 1; and_c[2][1] = 1; and_t[2][0] = 1;
    and_t[3][2] = 1; and_t[3][1] = 1; and_t[3][0] = 1;
    and_t[4][0] = 1; and_t[4][1] = 1;
    and_t[5][0] = 1; and_t[5][2] = 1;
    and_t[6][1] = 1; and_t[6][2] = 1;
    and_t[8][0] = 1; and_c[8][0] = 1;
    for (int p = 0; p < 4; p++) or_s[0][p] = 1;
    for (int p = 4; p < 7; p++) or_s[1][p] = 1;
    or_s[2][7] = 1; or_s[3][8] = 1;
    #1 rst_n = 1'b0;
    #54 rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R11", "reset done", int'(done_c), 0);
    chk("R11", "reset out", int'(out_r), 0);
    #5;
    cur_req = "R6 R7"; load_all();
    cur_req = "R1 R2 R10"; sweep_adder();
    cur_req = "R8";
    for (int k = 0; k < 20; k++) begin
      cfg_valid = 1'b1; cfg_data = k[0]; in_vec = N'(k); step();
    end
    cfg_valid = 1'b0;
    cur_req = "R5 R8"; sweep_adder();
    in_vec = 3'b111; @(negedge clk); #1;
    chk("R5", "empty output", int'(out_c[4]), 0);
    chk("R2", "all-ones pattern", int'(out_c), 5'b00111);
    #5;
    cur_req = "R11"; rst_n = 1'b0;
    #3;
    chk("R11", "async clear done", int'(done_r), 0);
    chk("R11", "async clear out", int'(out_c | out_r), 0);
    step(); rst_n = 1'b1; step();
    or_s[4][7] = 1; or_s[4][0] = 1;
    cur_req = "R6 R11"; load_all();
    cur_req = "R2 R9"; sweep_adder();
    in_vec = 3'b000; @(negedge clk); #1;
    chk("R2", "reloaded output", int'(out_c[4]), 1);
    #5; step();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R6 actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule